// File: doc/BRIEF.md
# Word Load/Store Address Generator

This block forms the effective byte address for word-sized loads and stores. A request names one of four addressing modes, a base address register, a displacement field, the value of a 16-bit general register used as an index, the width of the transfer and its direction. The block keeps its own bank of 22-bit address registers. These registers are filled through a dedicated write port. One cycle after a request is accepted, it presents a word-aligned 22-bit address together with the effective transfer width and the unchanged direction bit.

The stack pointer is not a separate register. Stack-relative requests read the highest-numbered address register. Short displacements are carried already halved and are doubled before the add. The long displacement and the index are added unscaled. Every sum wraps modulo 2^22, and bit 0 of the result is always cleared. Fetch, decode, the memory array and register writeback sit outside this block.

Top module: `word_agu`

## Requirements
- R1: While reset is asserted, out_valid, out_addr, out_wide and out_dir are all 0.
- R2: Mode code 0 (stack-relative) yields A15 + 2*req_disp[7:0]. Bits 15:8 of req_disp are ignored.
- R3: In mode 0 the base is always address register 15, whatever value req_ai carries.
- R4: Mode code 1 (short) yields A[req_ai] + 2*req_disp[3:0]. Bits 15:4 of req_disp are ignored.
- R5: Mode code 2 (long) yields A[req_ai] + req_disp[15:0], unscaled.
- R6: Mode code 3 (indexed) yields A[req_ai] + req_rj, with req_rj zero-extended to 22 bits.
- R7: Bit 0 of out_addr is always 0, even when the sum is odd.
- R8: The add is modulo 2^22, and any carry out of bit 21 is dropped.
- R9: out_valid is high exactly one cycle after each cycle with req_valid high. While no request is accepted, out_addr, out_wide and out_dir hold their values.
- R10: out_dir equals the req_dir of the accepted request (1 = store, 0 = load).
- R11: out_wide equals req_wide (1 = 22-bit address-register transfer, 0 = 16-bit) in modes 1 to 3. In mode 0 it is forced to 0.
- R12: A write to an address register takes effect on the clock edge. A request in the same cycle as a write to its base register uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| areg_we | input | 1 | Address register write enable |
| areg_waddr | input | 4 | Address register write index |
| areg_wdata | input | 22 | Address register write value |
| req_valid | input | 1 | Request accepted this cycle |
| req_mode | input | 2 | Addressing mode code (0 stack, 1 short, 2 long, 3 indexed) |
| req_ai | input | 4 | Base address register index |
| req_disp | input | 16 | Displacement field |
| req_rj | input | 16 | Index general register value |
| req_wide | input | 1 | Requested transfer width (1 = 22-bit) |
| req_dir | input | 1 | Direction (1 = store, 0 = load) |
| out_valid | output | 1 | Address valid pulse |
| out_addr | output | 22 | Word-aligned effective address |
| out_wide | output | 1 | Effective transfer width |
| out_dir | output | 1 | Direction, passed through |

## Verification
The hardest case to reach from the ports is a request whose base register is being rewritten in the same cycle. The bench drives a write to A0 and a long-mode request on A0 on the same falling edge. It expects the old value first and the new value on the request that follows. Carry-out wrap needs base registers near the top of the 22-bit range, so A1 is preloaded with 0x3FFFFE and then combined with both an index and the largest long displacement.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_SP    = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_LONG  = 2'd2,
    MODE_INDEX = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_areg_bank.sv
module agu_areg_bank #(
  parameter int AW = 22,
  parameter int NUM = 16,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] regs_q [NUM];

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_reg
      logic          en;
      logic [AW-1:0] d;
      always_comb begin
        en = wr_en && (wr_idx == IW'(g));
        d  = en ? wr_data : regs_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= '0;
        else if (en) regs_q[g] <= d;
      end
    end
  endgenerate

  // read sees flop contents, so a same-cycle write is not yet visible
  always_comb rd_data = regs_q[rd_idx];
endmodule

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int SPW = 8,
  parameter int SHW = 4
) (
  input  agu_mode_e     mode,
  input  logic [DW-1:0] disp,
  input  logic [GW-1:0] rj,
  output logic [AW-1:0] offset
);
  localparam int SP_PAD = AW - SPW - 1;
  localparam int SH_PAD = AW - SHW - 1;
  localparam int DW_PAD = AW - DW;
  localparam int GW_PAD = AW - GW;

  always_comb begin
    unique case (mode)
      MODE_SP:    offset = {{SP_PAD{1'b0}}, disp[SPW-1:0], 1'b0};
      MODE_SHORT: offset = {{SH_PAD{1'b0}}, disp[SHW-1:0], 1'b0};
      MODE_LONG:  offset = {{DW_PAD{1'b0}}, disp};
      default:    offset = {{GW_PAD{1'b0}}, rj};
    endcase
  end
endmodule

// File: rtl/agu_add_align.sv
module agu_add_align #(
  parameter int AW = 22
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] sum;
  always_comb begin
    sum  = base + offset;
    addr = {sum[AW-1:1], 1'b0};
  end
endmodule

// File: rtl/word_agu.sv
module word_agu
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        areg_we,
  input  logic [3:0]  areg_waddr,
  input  logic [21:0] areg_wdata,
  input  logic        req_valid,
  input  logic [1:0]  req_mode,
  input  logic [3:0]  req_ai,
  input  logic [15:0] req_disp,
  input  logic [15:0] req_rj,
  input  logic        req_wide,
  input  logic        req_dir,
  output logic        out_valid,
  output logic [21:0] out_addr,
  output logic        out_wide,
  output logic        out_dir
);
  localparam int AW = 22;
  localparam int NUM = 16;
  localparam int IW = $clog2(NUM);
  localparam logic [IW-1:0] SP_IDX = IW'(NUM - 1);

  agu_mode_e     mode;
  logic [IW-1:0] base_idx;
  logic [AW-1:0] base_val;
  logic [AW-1:0] offset;
  logic [AW-1:0] addr_d;
  logic          wide_d;

  always_comb begin
    mode     = agu_mode_e'(req_mode);
    base_idx = (mode == MODE_SP) ? SP_IDX : req_ai;
    wide_d   = (mode == MODE_SP) ? 1'b0 : req_wide;
  end

  agu_areg_bank #(.AW(AW), .NUM(NUM)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(areg_we), .wr_idx(areg_waddr),
    .wr_data(areg_wdata), .rd_idx(base_idx), .rd_data(base_val)
  );

  agu_offset #(.AW(AW), .DW(16), .GW(16), .SPW(8), .SHW(4)) u_off (
    .mode(mode), .disp(req_disp), .rj(req_rj), .offset(offset)
  );

  agu_add_align #(.AW(AW)) u_add (
    .base(base_val), .offset(offset), .addr(addr_d)
  );

  logic          valid_n;
  logic [AW-1:0] addr_n;
  logic          wide_n, dir_n;

  always_comb begin
    valid_n = req_valid;
    addr_n  = req_valid ? addr_d  : out_addr;
    wide_n  = req_valid ? wide_d  : out_wide;
    dir_n   = req_valid ? req_dir : out_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_wide  <= 1'b0;
      out_dir   <= 1'b0;
    end else begin
      out_valid <= valid_n;
      out_addr  <= addr_n;
      out_wide  <= wide_n;
      out_dir   <= dir_n;
    end
  end
endmodule

// File: rtl/word_agu_chk.sv
module word_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_mode,
  input logic [15:0] req_disp,
  input logic [15:0] req_rj,
  input logic        req_dir,
  input logic [21:0] base_val,
  input logic        out_valid,
  input logic [21:0] out_addr,
  input logic        out_wide,
  input logic        out_dir
);
  logic [21:0] exp_idx, exp_long;
  always_comb begin
    exp_idx  = (base_val + {6'd0, req_rj})   & ~22'd1;
    exp_long = (base_val + {6'd0, req_disp}) & ~22'd1;
  end

  p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_addr) && $stable(out_wide) && $stable(out_dir)));
  p_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_dir == $past(req_dir)));
  p_spwide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd0) |=> !out_wide);
  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_addr[0]);
  p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3) |=> (out_addr == $past(exp_idx)));
  p_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd2) |=> (out_addr == $past(exp_long)));
endmodule

bind word_agu word_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .req_disp(req_disp), .req_rj(req_rj), .req_dir(req_dir),
  .base_val(base_val), .out_valid(out_valid), .out_addr(out_addr),
  .out_wide(out_wide), .out_dir(out_dir)
);

// File: tb/sim_word_agu.sv
`timescale 1ns/1ps
module sim_word_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        areg_we;
  logic [3:0]  areg_waddr;
  logic [21:0] areg_wdata;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic [3:0]  req_ai;
  logic [15:0] req_disp;
  logic [15:0] req_rj;
  logic        req_wide;
  logic        req_dir;
  logic        out_valid;
  logic [21:0] out_addr;
  logic        out_wide;
  logic        out_dir;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  word_agu u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  ai;
    logic [15:0] disp;
    logic [15:0] rj;
    logic        wide;
    logic        dir;
    logic [21:0] exp_addr;
    logic        exp_wide;
  } vec_t;

  localparam logic [21:0] AINIT [16] = '{
    22'h000100, 22'h3FFFFE, 22'h000000, 22'h012345,
    22'h000000, 22'h000001, 22'h000000, 22'h0ABCDE,
    22'h000000, 22'h000000, 22'h000000, 22'h000000,
    22'h000000, 22'h000000, 22'h000000, 22'h200000};

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd3, 16'hFF05, 16'h0000, 1'b1, 1'b1, 22'h20000A, 1'b0}, // R2 R3 R11
    '{2'd0, 4'd0, 16'h00FF, 16'h0000, 1'b0, 1'b0, 22'h2001FE, 1'b0}, // R2
    '{2'd1, 4'd0, 16'hFFF7, 16'h0000, 1'b1, 1'b0, 22'h00010E, 1'b1}, // R4
    '{2'd1, 4'd5, 16'h000F, 16'h0000, 1'b0, 1'b1, 22'h00001E, 1'b0}, // R4 R7
    '{2'd2, 4'd3, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 22'h022344, 1'b1}, // R5
    '{2'd2, 4'd0, 16'h0003, 16'h0000, 1'b0, 1'b0, 22'h000102, 1'b0}, // R5 R7
    '{2'd3, 4'd7, 16'h0000, 16'h8001, 1'b1, 1'b0, 22'h0B3CDE, 1'b1}, // R6 R7
    '{2'd3, 4'd1, 16'h0000, 16'h0004, 1'b0, 1'b1, 22'h000002, 1'b0}, // R6 R8
    '{2'd2, 4'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 22'h00FFFC, 1'b1}  // R8 R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_areg(input int idx, input logic [21:0] v);
    @(negedge clk);
    areg_we = 1'b1; areg_waddr = 4'(idx); areg_wdata = v;
    @(negedge clk);
    areg_we = 1'b0;
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_mode = v.mode; req_ai = v.ai;
    req_disp = v.disp; req_rj = v.rj; req_wide = v.wide; req_dir = v.dir;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; areg_we = 1'b0; areg_waddr = '0; areg_wdata = '0;
    req_valid = 1'b0; req_mode = '0; req_ai = '0; req_disp = '0;
    req_rj = '0; req_wide = 1'b0; req_dir = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 addr", 32'(out_addr), 32'd0);
    chk("R1 wide", 32'(out_wide), 32'd0);
    chk("R1 dir", 32'(out_dir), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) wr_areg(i, AINIT[i]);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      chk("R9 valid pulse", 32'(out_valid), 32'd1);
      chk("R2-R8 addr vector", 32'(out_addr), 32'(VECS[i].exp_addr));
      chk("R11 width", 32'(out_wide), 32'(VECS[i].exp_wide));
      chk("R10 dir", 32'(out_dir), 32'(VECS[i].dir));
    end

    // R9: no request, inputs wander, outputs hold
    for (int k = 0; k < 3; k++) begin
      req_mode = 2'(k); req_ai = 4'd3; req_disp = 16'h1234;
      req_wide = 1'b0; req_dir = 1'b1;
      @(negedge clk);
      chk("R9 idle valid", 32'(out_valid), 32'd0);
      chk("R9 hold addr", 32'(out_addr), 32'h00FFFC);
      chk("R9 hold dir", 32'(out_dir), 32'd0);
    end

    // R12: write A0 and read A0 in the same cycle
    @(negedge clk);
    areg_we = 1'b1; areg_waddr = 4'd0; areg_wdata = 22'h000500;
    req_valid = 1'b1; req_mode = 2'd2; req_ai = 4'd0; req_disp = 16'h0000;
    req_wide = 1'b0; req_dir = 1'b0;
    @(negedge clk);
    areg_we = 1'b0; req_valid = 1'b0;
    chk("R12 old value", 32'(out_addr), 32'h000100);
    issue('{2'd2, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 22'h000500, 1'b0});
    chk("R12 new value", 32'(out_addr), 32'h000500);

    // R3: rewrite A15, stack mode follows it
    wr_areg(15, 22'h3FFF00);
    issue('{2'd0, 4'd7, 16'h0080, 16'h0000, 1'b1, 1'b1, 22'h000000, 1'b0});
    chk("R3 R8 stack wrap", 32'(out_addr), 32'h000000);
    chk("R11 stack width", 32'(out_wide), 32'd0);

    // R1: asynchronous reset mid-run
    issue('{2'd3, 4'd7, 16'h0000, 16'h0001, 1'b1, 1'b1, 22'h0ABCDE, 1'b1});
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async addr", 32'(out_addr), 32'd0);
    chk("R1 async wide", 32'(out_wide), 32'd0);
    chk("R1 async dir", 32'(out_dir), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule